// File: doc/BRIEF.md
# Track Index and Sector Mark Generator

This block produces the rotational timing marks of one disk track. It runs on a byte-rate clock, with one tick per byte time. One revolution lasts `TRACK_BYTES` ticks, 24000 by default. An index pulse marks the start of every revolution, and that start is also the start of the first sector. A one-byte sector pulse marks the start of each later sector. A sector number output tells the controller which sector is passing under the head.

The number of sectors per track comes from a 2-bit switch code. A software-loaded override count can replace it. A restore pulse, issued at power-up, drops the override and returns control to the switches. The block finds the sector length as the integer quotient of the track length by the sector count, using a sequential divider. The first N-1 sectors get that length. The last sector takes whatever bytes remain, so it can be longer than the others. A changed count is picked up only at the following index, so no track ever mixes two geometries.

Top module: `track_marker`

## Requirements
- R1: The index output is high for the first `INDEX_W` ticks of every revolution (96 by default), and successive index rising edges are exactly `TRACK_BYTES` ticks apart.
- R2: No sector pulse is issued at the first sector. Each later sector k (1..N-1) starts with a sector pulse exactly one tick wide.
- R3: `sector_num` reads 0 while the index rises, and goes up by exactly one on the tick each sector pulse rises. It is 8 bits wide.
- R4: Sector k starts k*floor(TRACK_BYTES/N) ticks after the index rise. The last sector runs until the next index, so it lasts TRACK_BYTES-(N-1)*floor(TRACK_BYTES/N) ticks.
- R5: With no override held, the 2-bit `sw_code` selects the sector count: 0 gives 111, 1 gives 69, 2 gives 40 and 3 gives 21.
- R6: A one-tick `ovr_load` with an `ovr_value` from 3 to 255 replaces the switch count. A load with a value from 0 to 2 is ignored, and the previous count stays in force.
- R7: An override stays in force until the next valid load or a `restore` pulse. Changes on `sw_code` have no effect while the override is held. `restore` clears the override and takes priority over a load in the same tick.
- R8: A count change takes effect at the next index. The track already under way keeps its sector positions.
- R9: While reset is low, index, sector and `sector_num` are all 0. After reset is released, no pulse appears until the first quotient is ready. The first revolution then begins with an index pulse, within 40 ticks of the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-rate clock, one tick per byte time |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_code | input | 2 | Sector count switch code |
| ovr_load | input | 1 | One-tick strobe that loads an override count |
| ovr_value | input | 8 | Override sector count, valid from 3 to 255 |
| restore | input | 1 | Power-up restore: drops the override |
| index_o | output | 1 | Index pulse at the start of each revolution |
| sector_o | output | 1 | One-tick pulse at the start of sectors 1..N-1 |
| sector_num | output | 8 | Number of the sector under the head |

## Verification
The index pulse and the first sector pulse can be high in the same tick. This happens when the sector length is shorter than the index width: 255 sectors in a 24000-byte track give 94-byte sectors, which is less than a 96-byte index. The bench provokes the overlap by loading an override of 255 on a 3000-tick track with a 20-tick index, so sector 1 rises at tick 11 while the index is still high. It then checks three things independently: sector 1 keeps its exact offset and number, the index still falls at tick 20, and the next index arrives on time.

// File: rtl/track_marker_pkg.sv
// Shared definitions for the track mark generator.
// Assumes sector counts fit in 8 bits (3..255).
package track_marker_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        SW_DENSE  = 2'd0,
        SW_MEDIUM = 2'd1,
        SW_SPARSE = 2'd2,
        SW_LARGE  = 2'd3
    } sw_code_e;

    // Maps a switch code to its sector count.
    function automatic logic [CNT_W-1:0] sw_to_count(input logic [1:0] code);
        case (sw_code_e'(code))
            SW_DENSE:  return CNT_W'(111);
            SW_MEDIUM: return CNT_W'(69);
            SW_SPARSE: return CNT_W'(40);
            default:   return CNT_W'(21);
        endcase
    endfunction

endpackage

// File: rtl/tm_count_sel.sv
// Picks the sector count in force: an override register or the switch table.
// Assumes a valid override lies in 3..255. A restore clears the override and
// wins over a load in the same tick.
module tm_count_sel
    import track_marker_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sw_code,
    input  logic             ovr_load,
    input  logic [CNT_W-1:0] ovr_value,
    input  logic             restore,
    output logic [CNT_W-1:0] pend_cnt
);

    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(3);

    logic             ovr_held;
    logic [CNT_W-1:0] ovr_cnt;

    // Holds the override count and whether it is in force.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_held <= 1'b0;
            ovr_cnt  <= '0;
        end else if (restore) begin
            ovr_held <= 1'b0;
        end else if (ovr_load && (ovr_value >= MIN_CNT)) begin
            ovr_held <= 1'b1;
            ovr_cnt  <= ovr_value;
        end
    end

    // Selects the count that the next track should use.
    always_comb begin
        pend_cnt = ovr_held ? ovr_cnt : sw_to_count(sw_code);
    end

endmodule

// File: rtl/tm_divider.sv
// Restoring divider: finds floor(TRACK_BYTES / den_in).
// It restarts whenever den_in differs from the divisor it last used, and takes
// POS_W cycles per quotient. ready is high only when the quotient matches
// the present den_in. Assumes den_in is never zero.
module tm_divider
    import track_marker_pkg::*;
#(
    parameter int TRACK_BYTES = 24000,
    localparam int POS_W  = $clog2(TRACK_BYTES + 1),
    localparam int STEP_W = $clog2(POS_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] den_in,
    output logic [POS_W-1:0] quo,
    output logic             ready
);

    logic [CNT_W-1:0]  den_q;
    logic [CNT_W-1:0]  rem;
    logic [STEP_W-1:0] step;
    logic              busy;
    logic              valid;
    logic [CNT_W:0]    shifted;
    logic              fits;

    // Forms the trial remainder for this step.
    always_comb begin
        shifted = {rem, quo[POS_W-1]};
        fits    = (shifted >= {1'b0, den_q});
    end

    // Runs one quotient bit per cycle, restarting on a new divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            den_q <= '0;
            rem   <= '0;
            quo   <= '0;
            step  <= '0;
            busy  <= 1'b0;
            valid <= 1'b0;
        end else if ((den_in != den_q) || (!valid && !busy)) begin
            den_q <= den_in;
            rem   <= '0;
            quo   <= POS_W'(TRACK_BYTES);
            step  <= '0;
            busy  <= 1'b1;
            valid <= 1'b0;
        end else if (busy) begin
            rem  <= fits ? CNT_W'(shifted - {1'b0, den_q}) : shifted[CNT_W-1:0];
            quo  <= {quo[POS_W-2:0], fits};
            step <= step + 1'b1;
            if (step == STEP_W'(POS_W - 1)) begin
                busy  <= 1'b0;
                valid <= 1'b1;
            end
        end
    end

    // Flags a quotient that belongs to the present divisor.
    always_comb begin
        ready = valid && (den_in == den_q);
    end

endmodule

// File: rtl/tm_sequencer.sv
// Track position counter and sector boundary logic.
// The geometry (count and length) is latched only at the start of a
// revolution. Before the first quotient is ready it stays idle, with no pulses.
module tm_sequencer
    import track_marker_pkg::*;
#(
    parameter int TRACK_BYTES = 24000,
    parameter int INDEX_W     = 96,
    localparam int POS_W = $clog2(TRACK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready,
    input  logic [POS_W-1:0] quo,
    input  logic [CNT_W-1:0] pend_cnt,
    output logic             index_o,
    output logic             sector_o,
    output logic [CNT_W-1:0] sector_num
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(TRACK_BYTES - 1);
    localparam logic [POS_W-1:0] IDX_END  = POS_W'(INDEX_W);

    logic             run;
    logic [POS_W-1:0] trk_pos;
    logic [POS_W-1:0] sec_pos;
    logic [CNT_W-1:0] sec_num;
    logic [POS_W-1:0] act_len;
    logic [CNT_W-1:0] act_cnt;
    logic             sec_end;

    // Detects the last byte of a sector that is followed by another one.
    always_comb begin
        sec_end = (sec_pos == act_len - 1'b1) && (sec_num != act_cnt - 1'b1);
    end

    // Steps through the revolution and latches new geometry at index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            trk_pos <= '0;
            sec_pos <= '0;
            sec_num <= '0;
            act_len <= '0;
            act_cnt <= '0;
        end else if (!run || (trk_pos == LAST_POS)) begin
            trk_pos <= '0;
            sec_pos <= '0;
            sec_num <= '0;
            if (ready) begin
                run     <= 1'b1;
                act_len <= quo;
                act_cnt <= pend_cnt;
            end
        end else begin
            trk_pos <= trk_pos + 1'b1;
            if (sec_end) begin
                sec_pos <= '0;
                sec_num <= sec_num + 1'b1;
            end else begin
                sec_pos <= sec_pos + 1'b1;
            end
        end
    end

    // Decodes the pulses from the position registers.
    always_comb begin
        index_o    = run && (trk_pos < IDX_END);
        sector_o   = run && (sec_num != '0) && (sec_pos == '0);
        sector_num = sec_num;
    end

endmodule

// File: rtl/track_marker.sv
// Top of the track mark generator: count select, divider and sequencer.
// Assumes a byte-rate clock and TRACK_BYTES/255 >= 2.
module track_marker
    import track_marker_pkg::*;
#(
    parameter int TRACK_BYTES = 24000,
    parameter int INDEX_W     = 96,
    localparam int POS_W = $clog2(TRACK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sw_code,
    input  logic             ovr_load,
    input  logic [CNT_W-1:0] ovr_value,
    input  logic             restore,
    output logic             index_o,
    output logic             sector_o,
    output logic [CNT_W-1:0] sector_num
);

    logic [CNT_W-1:0] pend_cnt;
    logic [POS_W-1:0] quo;
    logic             ready;

    tm_count_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_code   (sw_code),
        .ovr_load  (ovr_load),
        .ovr_value (ovr_value),
        .restore   (restore),
        .pend_cnt  (pend_cnt)
    );

    tm_divider #(.TRACK_BYTES(TRACK_BYTES)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .den_in (pend_cnt),
        .quo    (quo),
        .ready  (ready)
    );

    tm_sequencer #(.TRACK_BYTES(TRACK_BYTES), .INDEX_W(INDEX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready      (ready),
        .quo        (quo),
        .pend_cnt   (pend_cnt),
        .index_o    (index_o),
        .sector_o   (sector_o),
        .sector_num (sector_num)
    );

endmodule

// File: rtl/tm_checker.sv
// Property checker for track_marker, attached by bind below.
module tm_checker
    import track_marker_pkg::*;
#(
    parameter int INDEX_W = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             index_o,
    input logic             sector_o,
    input logic [CNT_W-1:0] sector_num,
    input logic [CNT_W-1:0] pend_cnt
);

    logic [31:0] idx_run;

    // Counts consecutive cycles that the index has been high.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_run <= '0;
        else        idx_run <= index_o ? idx_run + 1 : '0;
    end

    AST_INDEX_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        index_o |-> (idx_run < INDEX_W)); // R1
    AST_NO_FIRST_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        sector_o |-> (sector_num != '0)); // R2
    AST_SECTOR_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sector_o |=> !sector_o); // R2
    AST_NUM_ZERO_AT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(index_o) |-> (sector_num == '0)); // R3
    AST_NUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sector_o) |-> (sector_num == $past(sector_num) + 1'b1)); // R3
    AST_NUM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$rose(sector_o) && !$rose(index_o)) |-> $stable(sector_num)); // R3
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt >= CNT_W'(3)); // R6

endmodule

bind track_marker tm_checker #(.INDEX_W(INDEX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .index_o    (index_o),
    .sector_o   (sector_o),
    .sector_num (sector_num),
    .pend_cnt   (pend_cnt)
);

// File: tb/track_marker_tb.sv
`timescale 1ns/1ps
module track_marker_tb;

    localparam int TRK  = 3000;
    localparam int IDXW = 20;

    typedef struct {
        bit    is_idx;
        int    off;
        int    num;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sw_code = 2'd0;
    logic       ovr_load = 1'b0;
    logic [7:0] ovr_value = 8'd0;
    logic       restore = 1'b0;
    logic       index_o, sector_o;
    logic [7:0] sector_num;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   mon_cyc = 0;
    int   sec_hi = 0;
    bit   seen_idx = 0;
    bit   idx_prev = 0;
    bit   sec_prev = 0;
    bit   done = 0;
    event idx_ev;

    always #2.5 clk = ~clk;

    track_marker #(.TRACK_BYTES(TRK), .INDEX_W(IDXW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_code(sw_code), .ovr_load(ovr_load),
        .ovr_value(ovr_value), .restore(restore), .index_o(index_o),
        .sector_o(sector_o), .sector_num(sector_num)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: pushes the expected marks of one whole revolution.
    task automatic expect_track(input int n, input string tag);
        int q = TRK / n;
        for (int k = 1; k < n; k++) exp_q.push_back('{1'b0, k * q, k, tag});
        exp_q.push_back('{1'b1, TRK, 0, {tag, "/R1/R4"}});
    endtask

    // Monitor: compares observed marks against the queue.
    always @(negedge clk) begin
        exp_t e;
        if (!rst_n) begin
            mon_cyc = 0; seen_idx = 0; idx_prev = 0; sec_prev = 0; sec_hi = 0;
        end else begin
            mon_cyc++;
            if (index_o && !idx_prev) begin
                if (!seen_idx) chk(mon_cyc <= 40, "R9", mon_cyc, 40, "first index delay");
                else if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    chk(e.is_idx, e.tag, 0, 1, "index before all sectors");
                    if (e.is_idx) chk(mon_cyc == e.off, e.tag, mon_cyc, e.off, "revolution length");
                    else while (exp_q.size() > 0 && !exp_q[0].is_idx) void'(exp_q.pop_front());
                    if (!e.is_idx && exp_q.size() > 0) void'(exp_q.pop_front());
                end
                chk(sector_num == 0, "R3", sector_num, 0, "number at index");
                seen_idx = 1;
                mon_cyc = 0;
                -> idx_ev;
            end
            if (!index_o && idx_prev) chk(mon_cyc == IDXW, "R1", mon_cyc, IDXW, "index width");
            if (sector_o) sec_hi++;
            if (sector_o && !sec_prev) begin
                if (exp_q.size() == 0 || exp_q[0].is_idx) begin
                    chk(1'b0, "R2", 1, 0, "unexpected sector pulse");
                end else begin
                    e = exp_q.pop_front();
                    chk(mon_cyc == e.off, {e.tag, "/R4"}, mon_cyc, e.off, "sector offset");
                    chk(int'(sector_num) == e.num, {e.tag, "/R3"}, sector_num, e.num, "sector number");
                end
            end
            if (!sector_o && sec_prev) begin
                chk(sec_hi == 1, "R2", sec_hi, 1, "sector pulse width");
                sec_hi = 0;
            end
            idx_prev = index_o;
            sec_prev = sector_o;
        end
    end

    task automatic mid_track();
        repeat (500) @(negedge clk);
    endtask

    task automatic pulse_load(input int v, input bit with_restore);
        @(negedge clk);
        ovr_load = 1'b1; ovr_value = 8'(v); restore = with_restore;
        @(negedge clk);
        ovr_load = 1'b0; restore = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!index_o && !sector_o && sector_num == 0, "R9", {index_o, sector_o, sector_num}, 0, "outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(!index_o, "R9", index_o, 0, "no index before quotient");
        // Track A: switch 0, changed mid-track; A must keep 111 sectors.
        @(idx_ev); expect_track(111, "R5/R8");
        mid_track(); sw_code = 2'd1;
        @(idx_ev); expect_track(69, "R5");
        mid_track(); sw_code = 2'd2;
        @(idx_ev); expect_track(40, "R5");
        mid_track(); sw_code = 2'd3;
        @(idx_ev); expect_track(21, "R5/R8");
        mid_track(); pulse_load(255, 1'b0);
        // 255 sectors: sector 1 rises while index is still high.
        @(idx_ev); expect_track(255, "R6");
        mid_track(); pulse_load(3, 1'b0);
        @(idx_ev); expect_track(3, "R6");
        mid_track(); pulse_load(2, 1'b0); sw_code = 2'd0;
        @(idx_ev); expect_track(3, "R6/R7");
        mid_track(); @(negedge clk); restore = 1'b1; @(negedge clk); restore = 1'b0;
        @(idx_ev); expect_track(111, "R7");
        mid_track(); pulse_load(7, 1'b1);
        @(idx_ev); expect_track(111, "R7");
        mid_track(); pulse_load(7, 1'b0);
        @(idx_ev); expect_track(7, "R4/R6");
        @(idx_ev);
        chk(exp_q.size() == 0, "R2", exp_q.size(), 0, "leftover expectations");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog expired: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule